// File: doc/BRIEF.md
# Timing generator sync controller

This block aligns the pixel and line counters of an image-sensor timing generator with timing supplied from outside the chip. In master mode it watches a sync pin whose sense is set by a register bit. While the effective sync level is low, the counters are held at zero. On the rising edge of that level they restart from zero. An optional suspend setting parks every clock output on a programmed idle pattern while sync is held. If no external pulse is available, software can build one: with the pin tied low, setting the polarity bit creates the release edge.

In slave mode the sync pin is ignored. The counters are instead realigned by the external frame and line strobes. A falling edge of the line strobe that follows a falling edge of the frame strobe zeroes both counters after a fixed number of master clocks. Every asynchronous input passes through a multi-flop synchroniser before edge detection. Configuration comes in through a small word-wide register write port.

Top module: `tg_sync_ctrl`

## Requirements
- R1: In master mode with polarity 0, after the sync pin rises, pixel and line counters read zero after clock edge SYNC_STAGES+1 and then count up by one per clock. In that first zero cycle both line strobe `hd_out` and frame strobe `vd_out` are high.
- R2: Polarity is bit 0 of the control word at address 0. The effective sync is the synchronised pin XOR this bit. With the bit at 1, a high pin holds the counters and a falling pin releases them.
- R3: In master mode, while effective sync is low, `pix_cnt`, `line_cnt`, `hd_out` and `vd_out` are zero. They reach this state SYNC_STAGES+1 edges after the pin enters the active phase.
- R4: Suspend is control bit 1. When it is 1, in master mode and with effective sync low, `clk_out` equals the idle pattern at address 2. When it is 0, `clk_out` follows `clk_in` during sync.
- R5: Output enable is control bit 3. While it is 0, `clk_out` equals the idle pattern whatever the mode. It is 0 after reset.
- R6: With the pin low and polarity 0, writing polarity 1 starts the counters. The pixel count reads k-1 after the k-th edge following the write edge.
- R7: Slave mode is control bit 2. After a falling frame strobe, the next falling edge of the line strobe zeroes both counters at clock edge SYNC_STAGES+SLAVE_LAT counted from the pin edge. In the following cycle `hd_out` is high.
- R8: In slave mode, a falling line strobe with no falling frame strobe since the last slave realignment leaves the counters running.
- R9: After slave mode is entered, the counters stay at zero until the first slave realignment. The sync pin has no effect in slave mode.
- R10: The pixel counter wraps to 0 after the value at address 1. The line counter increments on each wrap.
- R11: `hd_out` is high only while the counters run and the pixel count is 0. `vd_out` is high only when, in addition, the line count is 0.
- R12: After reset, the counters and strobes are 0, `clk_out` is all zero, and the line-last register is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | active-low asynchronous reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | ADDR_W | register address (0 control, 1 line last, 2 idle pattern) |
| wr_data | input | DATA_W | register write data |
| sync_in | input | 1 | asynchronous sync pin |
| vd_in | input | 1 | external frame strobe (slave mode) |
| hd_in | input | 1 | external line strobe (slave mode) |
| clk_in | input | NUM_OUT | clock waveforms from the pattern generator |
| clk_out | output | NUM_OUT | gated clock outputs |
| pix_cnt | output | PIX_W | pixel counter |
| line_cnt | output | LINE_W | line counter |
| hd_out | output | 1 | line strobe, high at pixel 0 |
| vd_out | output | 1 | frame strobe, high at pixel 0 of line 0 |

## Verification
The bench builds the block with an 8-bit pixel counter, a 4-bit line counter and eight clock outputs. With these sizes a line length of ten makes pixel and line wraps appear within a few dozen cycles. The bench keeps the default SLAVE_LAT of 34 and two synchroniser stages. The exact slave realignment edge can therefore be checked against the cycle before it, and against a line-strobe edge that arrives without a frame strobe.

// File: rtl/tg_sync_pkg.sv
package tg_sync_pkg;

   // control word, bit 3 down to bit 0
   typedef struct packed {
      logic out_en;   // bit 3: 0 parks every output on the idle pattern
      logic slave;    // bit 2: 1 selects strobe-driven realignment
      logic suspend;  // bit 1: park outputs while sync is held
      logic pol;      // bit 0: inverts the sync pin
   } ctrl_t;

   localparam int CTRL_W    = 4;
   localparam int ADDR_CTRL = 0;
   localparam int ADDR_LINE = 1;
   localparam int ADDR_IDLE = 2;

endpackage

// File: rtl/tg_sync_regs.sv
module tg_sync_regs
   import tg_sync_pkg::*;
#(
   parameter int ADDR_W  = 2,
   parameter int DATA_W  = 32,
   parameter int PIX_W   = 14,
   parameter int NUM_OUT = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [DATA_W-1:0]   wr_data,
   output ctrl_t               ctrl,
   output logic [PIX_W-1:0]    line_last,
   output logic [NUM_OUT-1:0]  idle_lvl
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
   localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(ADDR_LINE);
   localparam logic [ADDR_W-1:0] A_IDLE = ADDR_W'(ADDR_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl      <= '0;
         line_last <= '1;
         idle_lvl  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_CTRL:  ctrl      <= ctrl_t'(wr_data[CTRL_W-1:0]);
            A_LINE:  line_last <= wr_data[PIX_W-1:0];
            A_IDLE:  idle_lvl  <= wr_data[NUM_OUT-1:0];
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/tg_sync_cdc.sv
module tg_sync_cdc #(
   parameter int STAGES = 2,
   parameter int W      = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] st;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[0] <= '0;
            else        st[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= '0;
            else        st[i] <= st[i-1];
         end
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/tg_sync_slave.sv
module tg_sync_slave #(
   parameter int SLAVE_LAT = 34
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic vd_s,
   input  logic hd_s,
   output logic clr,
   output logic started
);

   localparam int LAT_W = $clog2(SLAVE_LAT + 1);
   localparam logic [LAT_W-1:0] LAT_END = LAT_W'(SLAVE_LAT - 1);

   logic             vd_d, hd_d;
   logic             vd_fall, hd_fall, launch;
   logic             armed, busy;
   logic [LAT_W-1:0] lat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vd_d <= 1'b0;
         hd_d <= 1'b0;
      end else begin
         vd_d <= vd_s;
         hd_d <= hd_s;
      end
   end

   assign vd_fall = en & vd_d & ~vd_s;
   assign hd_fall = en & hd_d & ~hd_s;
   assign launch  = hd_fall & (armed | vd_fall) & ~busy;
   assign clr     = en & busy & (lat_cnt == LAT_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
      end else if (!en || launch) begin
         armed <= 1'b0;
      end else if (vd_fall) begin
         armed <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         lat_cnt <= '0;
      end else if (!en) begin
         busy    <= 1'b0;
         lat_cnt <= '0;
      end else if (busy) begin
         if (lat_cnt == LAT_END) busy <= 1'b0;
         else                    lat_cnt <= lat_cnt + 1'b1;
      end else if (launch) begin
         busy    <= 1'b1;
         lat_cnt <= LAT_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   started <= 1'b0;
      else if (!en) started <= 1'b0;
      else if (clr) started <= 1'b1;
   end

endmodule

// File: rtl/tg_sync_count.sv
module tg_sync_count #(
   parameter int PIX_W  = 14,
   parameter int LINE_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              zero,
   input  logic [PIX_W-1:0]  line_last,
   output logic [PIX_W-1:0]  pix,
   output logic [LINE_W-1:0] line
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix  <= '0;
         line <= '0;
      end else if (zero) begin
         pix  <= '0;
         line <= '0;
      end else if (pix >= line_last) begin
         pix  <= '0;
         line <= line + 1'b1;
      end else begin
         pix  <= pix + 1'b1;
      end
   end

endmodule

// File: rtl/tg_sync_ctrl.sv
module tg_sync_ctrl
   import tg_sync_pkg::*;
#(
   parameter int ADDR_W      = 2,
   parameter int DATA_W      = 32,
   parameter int NUM_OUT     = 24,
   parameter int PIX_W       = 14,
   parameter int LINE_W      = 12,
   parameter int SYNC_STAGES = 2,
   parameter int SLAVE_LAT   = 34
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               sync_in,
   input  logic               vd_in,
   input  logic               hd_in,
   input  logic [NUM_OUT-1:0] clk_in,
   output logic [NUM_OUT-1:0] clk_out,
   output logic [PIX_W-1:0]   pix_cnt,
   output logic [LINE_W-1:0]  line_cnt,
   output logic               hd_out,
   output logic               vd_out
);

   localparam int N_ASYNC = 3;

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("tg_sync_ctrl: SYNC_STAGES must be at least 2");
   end
   if (SLAVE_LAT < 2) begin : g_bad_lat
      $error("tg_sync_ctrl: SLAVE_LAT must be at least 2");
   end
   if (DATA_W < NUM_OUT || DATA_W < PIX_W || DATA_W < CTRL_W) begin : g_bad_data
      $error("tg_sync_ctrl: DATA_W too narrow for a register");
   end

   ctrl_t              ctrl;
   logic [PIX_W-1:0]   line_last;
   logic [NUM_OUT-1:0] idle_lvl;
   logic [N_ASYNC-1:0] async_s;
   logic               sync_s, vd_s, hd_s;
   logic               mode_slave, out_en, sup_en;
   logic               eff_sync, eff_d, rise;
   logic               slv_clr, slv_started;
   logic               hold, zero, park, run_q;

   tg_sync_regs #(
      .ADDR_W (ADDR_W), .DATA_W(DATA_W), .PIX_W(PIX_W), .NUM_OUT(NUM_OUT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .ctrl(ctrl), .line_last(line_last), .idle_lvl(idle_lvl)
   );

   tg_sync_cdc #(.STAGES(SYNC_STAGES), .W(N_ASYNC)) u_cdc (
      .clk(clk), .rst_n(rst_n), .d({sync_in, vd_in, hd_in}), .q(async_s)
   );

   assign sync_s     = async_s[2];
   assign vd_s       = async_s[1];
   assign hd_s       = async_s[0];
   assign mode_slave = ctrl.slave;
   assign out_en     = ctrl.out_en;
   assign sup_en     = ctrl.suspend;

   // effective sync: active phase is low, release is the rising edge
   assign eff_sync = sync_s ^ ctrl.pol;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eff_d <= 1'b0;
      else        eff_d <= eff_sync;
   end

   assign rise = ~mode_slave & eff_sync & ~eff_d;

   tg_sync_slave #(.SLAVE_LAT(SLAVE_LAT)) u_slave (
      .clk(clk), .rst_n(rst_n), .en(mode_slave), .vd_s(vd_s), .hd_s(hd_s),
      .clr(slv_clr), .started(slv_started)
   );

   assign hold = mode_slave ? ~slv_started : ~eff_sync;
   assign zero = hold | rise | slv_clr;

   tg_sync_count #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_count (
      .clk(clk), .rst_n(rst_n), .zero(zero), .line_last(line_last),
      .pix(pix_cnt), .line(line_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          run_q <= 1'b0;
      else if (mode_slave) run_q <= slv_started | slv_clr;
      else                 run_q <= eff_sync;
   end

   assign hd_out = run_q & (pix_cnt == '0);
   assign vd_out = hd_out & (line_cnt == '0);

   assign park = ~out_en | (~mode_slave & sup_en & ~eff_sync);

   for (genvar b = 0; b < NUM_OUT; b++) begin : g_park
      assign clk_out[b] = park ? idle_lvl[b] : clk_in[b];
   end

endmodule

// File: rtl/tg_sync_ctrl_chk.sv
module tg_sync_ctrl_chk #(
   parameter int NUM_OUT = 24,
   parameter int PIX_W   = 14,
   parameter int LINE_W  = 12
) (
   input logic               clk,
   input logic               rst_n,
   input logic               mode_slave,
   input logic               out_en,
   input logic               sup_en,
   input logic               eff_sync,
   input logic               slv_clr,
   input logic [NUM_OUT-1:0] idle_lvl,
   input logic [NUM_OUT-1:0] clk_out,
   input logic [PIX_W-1:0]   pix_cnt,
   input logic [LINE_W-1:0]  line_cnt,
   input logic               hd_out,
   input logic               vd_out
);

   AST_RELEASE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_slave && eff_sync && !$past(eff_sync)) |=> (pix_cnt == '0 && line_cnt == '0 && hd_out)); // R1

   AST_HOLD_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_slave && !eff_sync) |=> (pix_cnt == '0 && line_cnt == '0 && !hd_out && !vd_out)); // R3

   AST_PARK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_slave && sup_en && !eff_sync) |-> (clk_out == idle_lvl)); // R4

   AST_OUT_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> (clk_out == idle_lvl)); // R5

   AST_SLAVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      slv_clr |-> mode_slave); // R7

   AST_SLAVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      slv_clr |=> (pix_cnt == '0 && line_cnt == '0 && hd_out)); // R7

   AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_cnt != '0) |-> (pix_cnt == $past(pix_cnt) + PIX_W'(1))); // R10

   AST_STROBE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      vd_out |-> (hd_out && pix_cnt == '0 && line_cnt == '0)); // R11

endmodule

bind tg_sync_ctrl tg_sync_ctrl_chk #(
   .NUM_OUT(NUM_OUT), .PIX_W(PIX_W), .LINE_W(LINE_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_slave(mode_slave), .out_en(out_en),
   .sup_en(sup_en), .eff_sync(eff_sync), .slv_clr(slv_clr), .idle_lvl(idle_lvl),
   .clk_out(clk_out), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
   .hd_out(hd_out), .vd_out(vd_out)
);

// File: tb/sim_tg_sync_ctrl.sv
module sim_tg_sync_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int STG        = 2;
   localparam int LAT        = 34;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        sync_in = 1'b0;
   logic        vd_in = 1'b1;
   logic        hd_in = 1'b1;
   logic [7:0]  clk_in = 8'h3C;
   logic [7:0]  clk_out;
   logic [7:0]  pix_cnt;
   logic [3:0]  line_cnt;
   logic        hd_out, vd_out;

   int total = 0;
   int bad   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tg_sync_ctrl #(
      .ADDR_W(2), .DATA_W(16), .NUM_OUT(8), .PIX_W(8), .LINE_W(4),
      .SYNC_STAGES(STG), .SLAVE_LAT(LAT)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .sync_in(sync_in), .vd_in(vd_in), .hd_in(hd_in), .clk_in(clk_in),
      .clk_out(clk_out), .pix_cnt(pix_cnt), .line_cnt(line_cnt),
      .hd_out(hd_out), .vd_out(vd_out)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); @(negedge clk);
      end
   endtask

   task automatic t_reset;
      chk("R12 pix", pix_cnt, 0);
      chk("R12 line", line_cnt, 0);
      chk("R12 hd", hd_out, 0);
      chk("R12 vd", vd_out, 0);
      chk("R12 clk_out", clk_out, 0);
   endtask

   task automatic t_outen;
      wr(2'd2, 16'h00A5);
      chk("R5 idle while disabled", clk_out, 8'hA5);
      wr(2'd0, 16'h0008);             // out_en only, suspend off, held in sync
      step(2);
      chk("R4 no suspend passes clk_in", clk_out, 8'h3C);
      chk("R3 held pix", pix_cnt, 0);
      wr(2'd0, 16'h0000);
      chk("R5 disabled parks", clk_out, 8'hA5);
   endtask

   task automatic t_master;
      wr(2'd1, 16'd9);
      wr(2'd0, 16'h000A);             // out_en + suspend
      step(3);
      chk("R4 suspend parks", clk_out, 8'hA5);
      chk("R3 held hd", hd_out, 0);
      @(negedge clk); sync_in = 1'b1;
      for (int k = 1; k <= 25; k++) begin
         @(posedge clk); @(negedge clk);
         if (k < STG + 1) begin
            chk("R1 before restart", pix_cnt, 0);
            chk("R11 hd before restart", hd_out, 0);
         end else begin
            chk("R1/R10 pix", pix_cnt, (k - STG - 1) % 10);
            chk("R10 line", line_cnt, (k - STG - 1) / 10);
            chk("R11 hd", hd_out, ((k - STG - 1) % 10) == 0);
            chk("R11 vd", vd_out, (k - STG - 1) == 0);
         end
         if (k == 1) chk("R4 still parked", clk_out, 8'hA5);
         if (k == 5) chk("R4 released outputs", clk_out, 8'h3C);
      end
      @(negedge clk); sync_in = 1'b0;
      for (int k = 1; k <= 5; k++) begin
         @(posedge clk); @(negedge clk);
         if (k >= STG) chk("R4 parked again", clk_out, 8'hA5);
         if (k >= STG + 1) begin
            chk("R3 re-held pix", pix_cnt, 0);
            chk("R3 re-held hd", hd_out, 0);
         end
      end
   endtask

   task automatic t_polarity;
      @(negedge clk); sync_in = 1'b1;
      step(10);
      wr(2'd0, 16'h000B);             // polarity 1: high pin now means held
      step(3);
      chk("R2 inverted hold", pix_cnt, 0);
      step(10);
      chk("R2 still held", pix_cnt, 0);
      @(negedge clk); sync_in = 1'b0;
      step(6);
      chk("R2 release on falling pin", pix_cnt, 6 - STG - 1);
   endtask

   task automatic t_soft;
      wr(2'd0, 16'h000A);             // pin low, polarity 0: held
      step(4);
      chk("R6 held before write", pix_cnt, 0);
      wr(2'd0, 16'h000B);
      chk("R6 write edge", pix_cnt, 0);
      for (int k = 1; k <= 6; k++) begin
         step(1);
         chk("R6 soft sync count", pix_cnt, k - 1);
      end
   endtask

   task automatic t_slave;
      int p0;
      wr(2'd1, 16'd99);
      wr(2'd0, 16'h000C);             // out_en + slave
      step(5);
      chk("R9 idle before strobes", pix_cnt, 0);
      @(negedge clk); sync_in = 1'b1;
      step(6);
      @(negedge clk); sync_in = 1'b0;
      step(6);
      chk("R9 sync pin ignored", pix_cnt, 0);
      // first frame starts the counters
      @(negedge clk); vd_in = 1'b0;
      step(4);
      vd_in = 1'b1;
      step(3);
      hd_in = 1'b0;
      for (int k = 1; k <= 40; k++) begin
         @(posedge clk); @(negedge clk);
         if (k == 5) hd_in = 1'b1;
         if (k == STG + LAT - 1) chk("R9 not started", pix_cnt, 0);
         if (k == STG + LAT) begin
            chk("R7 first realign", pix_cnt, 0);
            chk("R7 hd after realign", hd_out, 1);
         end
         if (k == 40) chk("R7 running", pix_cnt, 40 - STG - LAT);
      end
      // second frame realigns a running counter
      step(20);
      vd_in = 1'b0;
      step(4);
      vd_in = 1'b1;
      step(3);
      p0 = pix_cnt;
      hd_in = 1'b0;
      for (int k = 1; k <= 40; k++) begin
         @(posedge clk); @(negedge clk);
         if (k == 5) hd_in = 1'b1;
         if (k == STG + LAT - 1) chk("R7 not yet", pix_cnt, (p0 + k) % 100);
         if (k == STG + LAT) begin
            chk("R7 realign pix", pix_cnt, 0);
            chk("R7 realign line", line_cnt, 0);
         end
         if (k == 40) chk("R7 after realign", pix_cnt, 40 - STG - LAT);
      end
      // line strobe with no frame strobe
      step(10);
      p0 = pix_cnt;
      hd_in = 1'b0;
      for (int k = 1; k <= 40; k++) begin
         @(posedge clk); @(negedge clk);
         if (k == 5) hd_in = 1'b1;
         if (k == STG + LAT) chk("R8 no realign", pix_cnt, (p0 + k) % 100);
         if (k == 40) chk("R8 still running", pix_cnt, (p0 + k) % 100);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step(2);
      t_reset();
      t_outen();
      t_master();
      t_polarity();
      t_soft();
      t_slave();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule